// File: doc/BRIEF.md
# Chainable 24-bit serial command frame receiver

This block is the serial front end of a digitally controlled potentiometer. It watches the chip-select, clock and data-in pins of an SPI-style link. Each pin passes through a two-flop synchroniser into the system clock, and pin edges are found in that domain. While the device is selected, a data bit is shifted into a 24-bit register on every rising serial clock, most significant bit first. When chip select rises, a completed command is handed to the command logic as a one-cycle strobe. The command is split into a 4-bit opcode, a 2-bit memory slot, a 2-bit channel and a 16-bit data field.

The serial output is open drain. During a transfer it shifts out whatever the register held before that transfer began. A train of 24 bits therefore pushes the previous frame on to the next device, so several devices can share one chip select in a chain. The command logic can replace the register contents with a 9-bit response while the device is idle, and that response then leaves on the serial output during the next transfer. A transfer is executed only if its bit count is a non-zero multiple of 24. After reset, the device accepts nothing until chip select has gone from high to low.

Top module: `spi_frame_rx`

## Requirements
- R1: While reset is asserted and right after it, `sdo_pull_low` is 0 and `frame_valid` is 0.
- R2: A 24-bit transfer raises `frame_valid` for exactly one system clock after chip select rises. The last 24 bits received, first-received bit as bit 23, are split this way: bits 23..20 give `frame_opcode`, bits 19..18 give `frame_slot`, bits 17..16 give `frame_chan` and bits 15..0 give `frame_data`.
- R3: A transfer whose bit count is zero or not a multiple of 24 produces no `frame_valid`. A 48-bit transfer produces one frame made of the last 24 bits sent.
- R4: During a transfer, the serial output presents the register contents held before the transfer, MSB first. The first bit is valid after chip select falls and before the first rising clock. Each later bit is valid after the preceding falling clock.
- R5: While chip select is high, `sdo_pull_low` is 0 (released) even when the register's top bit is 0. While selected, `sdo_pull_low` is 1 exactly when the output bit is 0.
- R6: After reset, a transfer made with chip select already low, with no high-to-low transition seen, is ignored. It gives no `frame_valid` and `sdo_pull_low` stays 0.
- R7: A `rsp_valid` pulse while chip select is high loads the register with `rsp_data` in bits 8..0 and zeros above. The next transfer shifts out 15 zeros followed by the 9 response bits.
- R8: A `rsp_valid` pulse while chip select is low has no effect. The next transfer shifts out the frame that was received.
- R9: With two devices chained, where the first device's serial output drives the second device's input, a 48-bit transfer leaves the last 24 bits in the first device and the first 24 bits in the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock pin (asynchronous) |
| spi_csn | input | 1 | Active-low chip select pin (asynchronous) |
| spi_sdi | input | 1 | Serial data in pin (asynchronous) |
| sdo_pull_low | output | 1 | 1 pulls the open-drain serial output low, 0 releases it |
| frame_valid | output | 1 | One-cycle strobe for an accepted frame |
| frame_opcode | output | 4 | Frame bits 23..20 |
| frame_slot | output | 2 | Frame bits 19..18 |
| frame_chan | output | 2 | Frame bits 17..16 |
| frame_data | output | 16 | Frame bits 15..0 |
| rsp_valid | input | 1 | Load response into shift register (honoured only while deselected) |
| rsp_data | input | 9 | Response value placed in register bits 8..0 |

## Verification
The hardest behaviour to reach from the ports is the chained case. There, the output of one device must be retimed through another device's synchronisers and land on that device's own rising clocks. The bench builds a real two-device chain: the first device's pull-low output, inverted as an external pull-up would leave it, feeds the second device's data input. A single 48-bit transfer then shows that each device keeps its own half. The power-up guard is reached by holding chip select low across reset and clocking a full frame before any falling edge of chip select.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int FRAME_BITS = 24;
  localparam int PH_W       = $clog2(FRAME_BITS);
  localparam int RSP_BITS   = 9;

  typedef struct packed {
    logic [3:0]  opcode;
    logic [1:0]  slot;
    logic [1:0]  chan;
    logic [15:0] data;
  } frame_t;

  // advance the bit position within a frame, wrapping after the last bit
  function automatic logic [PH_W-1:0] phase_step(input logic [PH_W-1:0] p);
    return (p == PH_W'(FRAME_BITS - 1)) ? '0 : p + 1'b1;
  endfunction

  // a frame is taken only at a whole-frame boundary after at least one frame
  function automatic logic frame_accept(input logic [PH_W-1:0] p, input logic full);
    return full && (p == '0);
  endfunction

  function automatic frame_t split_frame(input logic [FRAME_BITS-1:0] w);
    frame_t f;
    f.opcode = w[23:20];
    f.slot   = w[19:18];
    f.chan   = w[17:16];
    f.data   = w[15:0];
    return f;
  endfunction
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RESET_VAL}};
    else        ff <= {ff[STAGES-2:0], din};
  end

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter
  import sfr_pkg::*;
#(
  parameter int RB = RSP_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  csn_s,
  input  logic                  mosi_s,
  input  logic                  rsp_valid,
  input  logic [RB-1:0]         rsp_data,
  output logic                  sdo_bit,
  output logic                  sdo_en,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_word
);
  logic sclk_q, csn_q;
  logic armed, full_seen;
  logic [PH_W-1:0] bit_phase;
  logic [FRAME_BITS-1:0] sr;

  // named internal events
  wire sclk_rise = sclk_s & ~sclk_q;
  wire sclk_fall = ~sclk_s & sclk_q;
  wire cs_fall   = ~csn_s & csn_q;
  wire cs_rise   = csn_s & ~csn_q;
  wire active    = armed & ~csn_s;
  wire shift_en  = active & sclk_rise;
  wire rsp_load  = rsp_valid & csn_s;
  wire accept    = cs_rise & armed & frame_accept(bit_phase, full_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (cs_fall) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_phase <= '0;
      full_seen <= 1'b0;
    end else if (cs_fall) begin
      bit_phase <= '0;
      full_seen <= 1'b0;
    end else if (shift_en) begin
      bit_phase <= phase_step(bit_phase);
      if (bit_phase == PH_W'(FRAME_BITS - 1)) full_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (shift_en) sr <= {sr[FRAME_BITS-2:0], mosi_s};
    else if (rsp_load) sr <= {{(FRAME_BITS-RB){1'b0}}, rsp_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo_bit <= 1'b1;
    else if (cs_fall || (active && sclk_fall)) sdo_bit <= sr[FRAME_BITS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      frame_word  <= '0;
    end else begin
      frame_valid <= accept;
      if (accept) frame_word <= sr;
    end
  end

  assign sdo_en = active;

  // R2
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  // R3
  frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (bit_phase == '0 && full_seen));
  // R6
  frame_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> armed);
  // R7
  rsp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> (sr[RB-1:0] == $past(rsp_data)));
  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sclk_fall && !cs_fall) |=> $stable(sdo_bit));
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import sfr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RB          = RSP_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_csn,
  input  logic          spi_sdi,
  output logic          sdo_pull_low,
  output logic          frame_valid,
  output logic [3:0]    frame_opcode,
  output logic [1:0]    frame_slot,
  output logic [1:0]    frame_chan,
  output logic [15:0]   frame_data,
  input  logic          rsp_valid,
  input  logic [RB-1:0] rsp_data
);
  logic sclk_s, csn_s, mosi_s;
  logic sdo_bit, sdo_en;
  logic [FRAME_BITS-1:0] frame_word;
  frame_t fields;

  sfr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .din(spi_sclk), .dout(sclk_s));
  // reset to "selected" so that only a genuine high-to-low transition arms
  sfr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_csn (
    .clk(clk), .rst_n(rst_n), .din(spi_csn), .dout(csn_s));
  sfr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .din(spi_sdi), .dout(mosi_s));

  sfr_shifter #(.RB(RB)) u_shifter (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sdo_bit(sdo_bit), .sdo_en(sdo_en),
    .frame_valid(frame_valid), .frame_word(frame_word));

  assign fields       = split_frame(frame_word);
  assign frame_opcode = fields.opcode;
  assign frame_slot   = fields.slot;
  assign frame_chan   = fields.chan;
  assign frame_data   = fields.data;
  assign sdo_pull_low = sdo_en & ~sdo_bit;

  // R5
  sdo_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !sdo_pull_low);
endmodule

// File: tb/spi_frame_rx_bench.sv
module spi_frame_rx_bench;
  localparam int HALF = 8;
  localparam int NV   = 4;
  // {frame, opcode, slot, chan, data}
  localparam logic [47:0] VEC [NV] = '{
    {24'h4000C3, 4'h4, 2'd0, 2'd0, 16'h00C3},
    {24'h2D0155, 4'h2, 2'd3, 2'd1, 16'h0155},
    {24'hB800FF, 4'hB, 2'd2, 2'd0, 16'h00FF},
    {24'hF3FE01, 4'hF, 2'd0, 2'd3, 16'hFE01}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk, csn, mosi, rsp_valid;
  logic [8:0] rsp_data;
  logic n_pull, n_fv, f_pull, f_fv;
  logic [3:0] n_op, f_op;
  logic [1:0] n_slot, n_chan, f_slot, f_chan;
  logic [15:0] n_data, f_data;
  logic far_sdi;

  spi_frame_rx u_spi_frame_rx (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(mosi),
    .sdo_pull_low(n_pull), .frame_valid(n_fv), .frame_opcode(n_op),
    .frame_slot(n_slot), .frame_chan(n_chan), .frame_data(n_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  assign far_sdi = ~n_pull;  // open drain with pull-up

  spi_frame_rx u_far (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(far_sdi),
    .sdo_pull_low(f_pull), .frame_valid(f_fv), .frame_opcode(f_op),
    .frame_slot(f_slot), .frame_chan(f_chan), .frame_data(f_data),
    .rsp_valid(1'b0), .rsp_data(9'h0));

  int n_checks = 0, n_fail = 0;
  int n_cnt = 0, f_cnt = 0;
  logic [23:0] n_last, f_last;

  always @(negedge clk) begin
    if (n_fv) begin n_cnt++; n_last <= {n_op, n_slot, n_chan, n_data}; end
    if (f_fv) begin f_cnt++; f_last <= {f_op, f_slot, f_chan, f_data}; end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench restatement of the split: opcode/slot/chan/data are plain slices
  function automatic logic [23:0] fields_of(input logic [23:0] w);
    return {w[23:20], w[19:18], w[17:16], w[15:0]};
  endfunction

  task automatic xfer(input int nbits, input logic [47:0] bits, input int rsp_at,
                      output logic [47:0] cap);
    cap = '0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[nbits-1-i];
      wait_clk(HALF);
      cap = {cap[46:0], ~n_pull};
      sclk = 1'b1;
      if (i == rsp_at) begin
        rsp_valid = 1'b1; wait_clk(1); rsp_valid = 1'b0; wait_clk(HALF-1);
      end else wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(3*HALF);
  endtask

  initial begin
    #(4*150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [47:0] cap;
    logic [23:0] prev;
    int c0, f0;
    rst_n = 1'b0; csn = 1'b0; sclk = 1'b0; mosi = 1'b0;
    rsp_valid = 1'b0; rsp_data = '0;
    wait_clk(5);
    chk("R1 pull_low in reset", {47'b0, n_pull}, 48'd0);
    chk("R1 frame_valid in reset", {47'b0, n_fv}, 48'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R1 pull_low after reset", {47'b0, n_pull}, 48'd0);

    // R6: chip select low since reset, never seen falling
    c0 = n_cnt;
    xfer(24, {24'h0, 24'hA55A5A}, -1, cap);
    chk("R6 output released while unarmed", cap, {24'h0, 24'hFFFFFF});
    chk("R6 no frame while unarmed", 48'(n_cnt - c0), 48'd0);

    // R2/R4 vector table
    prev = 24'h0;
    for (int k = 0; k < NV; k++) begin
      c0 = n_cnt;
      xfer(24, {24'h0, VEC[k][47:24]}, -1, cap);
      chk("R2 one frame strobe", 48'(n_cnt - c0), 48'd1);
      chk("R2 frame fields", {24'h0, n_last}, {24'h0, VEC[k][23:0]});
      chk("R4 previous contents shifted out", cap, {24'h0, prev});
      prev = VEC[k][47:24];
    end

    // R3: invalid counts
    c0 = n_cnt;
    xfer(25, {23'h0, 25'h1234567}, -1, cap);
    chk("R3 25-bit transfer ignored", 48'(n_cnt - c0), 48'd0);
    c0 = n_cnt;
    xfer(0, 48'h0, -1, cap);
    chk("R3 empty transfer ignored", 48'(n_cnt - c0), 48'd0);

    // R3 + R9: 48-bit transfer through the chain
    c0 = n_cnt; f0 = f_cnt;
    xfer(48, {24'h701234, 24'h35ABCD}, -1, cap);
    chk("R3 48-bit gives one frame", 48'(n_cnt - c0), 48'd1);
    chk("R3 last 24 bits kept", {24'h0, n_last}, {24'h0, fields_of(24'h35ABCD)});
    chk("R9 far device frame count", 48'(f_cnt - f0), 48'd1);
    chk("R9 far device holds first 24 bits", {24'h0, f_last}, {24'h0, fields_of(24'h701234)});

    // R5: register MSB is 0 now, but deselected output must be released
    chk("R5 released while deselected", {47'b0, n_pull}, 48'd0);

    // R7: response load while idle
    rsp_data = 9'h1A5; rsp_valid = 1'b1; wait_clk(1); rsp_valid = 1'b0;
    wait_clk(4);
    xfer(24, 48'h0, -1, cap);
    chk("R7 response shifted out", cap, {24'h0, 24'h0001A5});

    // R8: response pulse mid-transfer ignored
    rsp_data = 9'h0F0;
    xfer(24, {24'h0, 24'h6C9E21}, 10, cap);
    xfer(24, 48'h0, -1, cap);
    chk("R8 mid-frame response ignored", cap, {24'h0, 24'h6C9E21});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule